// File: doc/BRIEF.md
# SHA-1 Message Schedule Expander

This block computes SHA-1 message schedule words four at a time. Each operand is a packed 128-bit vector of four 32-bit lanes. The earliest word in time sits in the most significant lane, bits [127:96].

Two operations are offered:

- **Partial-term mix.** This builds XOR partial terms from six consecutive schedule words.
- **Finish.** This folds in the three most recent words and applies a one-bit left rotate. The result is the next four schedule words.

Between the two operations the caller XORs in the four words that lie eight positions back. Repeating the pair sixteen times expands the sixteen words of a 512-bit block into all eighty.

Requests use a valid/ready handshake that carries an opcode and two operands. The result sits in a single output register, and a new request can be taken in the same cycle that the previous result is consumed. Opcodes outside the two defined codes return an all-zero result with an error flag.

Top module: `sha1_sched_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `res_valid` is 0, `res_data` is all zero and `op_ready` is 1.
- R2: Opcode 2'b01 (mix). Call the lanes of `op_a` from [127:96] down to [31:0] a0..a3, and the lanes `op_b`[127:96] and `op_b`[95:64] b0 and b1. The result lanes, from high to low, are a2^a0, a3^a1, b0^a2 and b1^a3. The low half of `op_b` has no effect.
- R3: Opcode 2'b10 (finish). Call the lanes of `op_a` p0..p3, high to low. The three upper result lanes are ROL1(p0^`op_b`[95:64]), ROL1(p1^`op_b`[63:32]) and ROL1(p2^`op_b`[31:0]).
- R4: Opcode 2'b10 (finish). The lowest result lane is ROL1(p3^X), where X is the value of the highest result lane of the same operation. `op_b`[127:96] has no effect.
- R5: Opcodes 2'b00 and 2'b11 give an all-zero result with `res_err` = 1. Opcodes 2'b01 and 2'b10 give `res_err` = 0.
- R6: A request accepted at a clock edge (`op_valid` and `op_ready` both 1) shows its result with `res_valid` = 1 directly after that edge.
- R7: While `res_valid` = 1 and `res_ready` = 0, `res_data` and `res_err` stay unchanged and `op_ready` is 0.
- R8: When `res_valid` and `res_ready` are both 1, `op_ready` is 1. A request offered in that cycle replaces the result at the same edge. With no request offered, `res_valid` falls to 0.
- R9: Each group works as follows: mix of {W[t-16..t-13]} and {W[t-12],W[t-11],-,-}, then XOR with {W[t-8..t-5]}, then finish with operand B {-,W[t-3],W[t-2],W[t-1]}. The finish returns {W[t..t+3]} of the recurrence W[t] = ROL1(W[t-3]^W[t-8]^W[t-14]^W[t-16]), for every t from 16 to 76 in steps of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Request accepted at this edge when `op_valid` is 1 |
| op_code | input | 2 | 01 = mix, 10 = finish, others undefined |
| op_a | input | 128 | First operand, four lanes, earliest word in [127:96] |
| op_b | input | 128 | Second operand, same packing |
| res_valid | output | 1 | Result held in the output register |
| res_ready | input | 1 | Consumer takes the result at this edge |
| res_data | output | 128 | Four result lanes |
| res_err | output | 1 | Result came from an undefined opcode |

## Verification
Result hand-off and request acceptance can land on the same edge. So can a held result and a blocked request. The bench first leaves a finished result unconsumed while a second request waits with `op_valid` high. It checks that the output and the error flag do not move and that `op_ready` stays low. It then raises `res_ready` without dropping the request and checks that the second result replaces the first at that single edge. Finally it checks that `res_valid` falls once no further request follows.

// File: rtl/sha1_sched_pkg.sv
package sha1_sched_pkg;

   localparam int LANES = 4;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_MIX  = 2'b01,
      OP_FIN  = 2'b10,
      OP_RSV  = 2'b11
   } sched_op_e;

endpackage

// File: rtl/sha1_sched_mix.sv
module sha1_sched_mix #(
   parameter int WORD_W = 32,
   localparam int VEC_W = sha1_sched_pkg::LANES * WORD_W
) (
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic [VEC_W-1:0] mix_o
);
   import sha1_sched_pkg::*;

   localparam int EXT_N = LANES + 2;

   logic [WORD_W-1:0] ext [EXT_N];
   logic              unused_b_low;

   assign unused_b_low = ^src_b[VEC_W/2-1:0];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_a
         assign ext[g] = src_a[VEC_W-1-g*WORD_W -: WORD_W];
      end
      for (genvar g = 0; g < 2; g++) begin : g_b
         assign ext[LANES+g] = src_b[VEC_W-1-g*WORD_W -: WORD_W];
      end
      for (genvar g = 0; g < LANES; g++) begin : g_out
         assign mix_o[VEC_W-1-g*WORD_W -: WORD_W] = ext[g+2] ^ ext[g];
      end
   endgenerate

endmodule

// File: rtl/sha1_sched_fin.sv
module sha1_sched_fin #(
   parameter int WORD_W = 32,
   localparam int VEC_W = sha1_sched_pkg::LANES * WORD_W
) (
   input  logic [VEC_W-1:0] part_i,
   input  logic [VEC_W-1:0] recent_i,
   output logic [VEC_W-1:0] fin_o
);
   import sha1_sched_pkg::*;

   logic [WORD_W-1:0] pre  [LANES];
   logic [WORD_W-1:0] word [LANES];
   logic              unused_recent_top;

   assign unused_recent_top = ^recent_i[VEC_W-1 -: WORD_W];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         if (g < LANES - 1) begin : g_direct
            assign pre[g] = part_i[VEC_W-1-g*WORD_W -: WORD_W]
                          ^ recent_i[VEC_W-1-(g+1)*WORD_W -: WORD_W];
         end else begin : g_chain
            // last lane consumes the word produced in lane zero
            assign pre[g] = part_i[VEC_W-1-g*WORD_W -: WORD_W] ^ word[0];
         end
         assign word[g] = {pre[g][WORD_W-2:0], pre[g][WORD_W-1]};
         assign fin_o[VEC_W-1-g*WORD_W -: WORD_W] = word[g];
      end
   endgenerate

endmodule

// File: rtl/sha1_sched_hold.sv
module sha1_sched_hold #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_err,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_err
);
   logic load;

   assign in_ready = !out_valid || out_ready;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_err   <= 1'b0;
      end else begin
         if (load) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_err   <= in_err;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sha1_sched_unit.sv
module sha1_sched_unit #(
   parameter int WORD_W = 32,
   localparam int VEC_W = sha1_sched_pkg::LANES * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   output logic             op_ready,
   input  logic [1:0]       op_code,
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   output logic             res_valid,
   input  logic             res_ready,
   output logic [VEC_W-1:0] res_data,
   output logic             res_err
);
   import sha1_sched_pkg::*;

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("sha1_sched_unit: WORD_W must be at least 2");
      end
      if (LANES != 4) begin : g_bad_lanes
         $error("sha1_sched_unit: lane ordering assumes four lanes");
      end
   endgenerate

   logic [VEC_W-1:0] mix_res;
   logic [VEC_W-1:0] fin_res;
   logic [VEC_W-1:0] sel_res;
   logic             sel_err;

   sha1_sched_mix #(.WORD_W(WORD_W)) u_mix (
      .src_a (op_a),
      .src_b (op_b),
      .mix_o (mix_res)
   );

   sha1_sched_fin #(.WORD_W(WORD_W)) u_fin (
      .part_i   (op_a),
      .recent_i (op_b),
      .fin_o    (fin_res)
   );

   always_comb begin
      sel_res = '0;
      sel_err = 1'b1;
      case (sched_op_e'(op_code))
         OP_MIX: begin
            sel_res = mix_res;
            sel_err = 1'b0;
         end
         OP_FIN: begin
            sel_res = fin_res;
            sel_err = 1'b0;
         end
         default: begin
            sel_res = '0;
            sel_err = 1'b1;
         end
      endcase
   end

   sha1_sched_hold #(.DATA_W(VEC_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (op_valid),
      .in_ready  (op_ready),
      .in_data   (sel_res),
      .in_err    (sel_err),
      .out_valid (res_valid),
      .out_ready (res_ready),
      .out_data  (res_data),
      .out_err   (res_err)
   );

endmodule

// File: rtl/sha1_sched_chk.sv
module sha1_sched_chk #(
   parameter int WORD_W = 32,
   localparam int VEC_W = 4 * WORD_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic             op_ready,
   input logic [1:0]       op_code,
   input logic [VEC_W-1:0] op_a,
   input logic             res_valid,
   input logic             res_ready,
   input logic [VEC_W-1:0] res_data,
   input logic             res_err
);
   logic accept;
   assign accept = op_valid && op_ready;

   // R6
   result_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> res_valid);

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_err)));

   // R7
   blocked_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |-> !op_ready);

   // R8
   drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ready && !op_valid) |=> !res_valid);

   // R5
   bad_op_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (op_code == 2'b00 || op_code == 2'b11)) |=> (res_err && res_data == '0));

   // R5
   good_op_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (op_code == 2'b01 || op_code == 2'b10)) |=> !res_err);

   // R2
   mix_top_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_code == 2'b01) |=>
      res_data[VEC_W-1 -: WORD_W] ==
         ($past(op_a[VEC_W-1 -: WORD_W]) ^ $past(op_a[VEC_W-1-2*WORD_W -: WORD_W])));

endmodule

bind sha1_sched_unit sha1_sched_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_ready  (op_ready),
   .op_code   (op_code),
   .op_a      (op_a),
   .res_valid (res_valid),
   .res_ready (res_ready),
   .res_data  (res_data),
   .res_err   (res_err)
);

// File: tb/sha1_sched_unit_tb.sv
module sha1_sched_unit_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic         op_ready;
   logic [1:0]   op_code = 2'b00;
   logic [127:0] op_a = '0;
   logic [127:0] op_b = '0;
   logic         res_valid;
   logic         res_ready = 1'b1;
   logic [127:0] res_data;
   logic         res_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sha1_sched_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
      .op_a(op_a), .op_b(op_b),
      .res_valid(res_valid), .res_ready(res_ready),
      .res_data(res_data), .res_err(res_err)
   );

   localparam int NV = 7;
   localparam string T_TAG [NV] = '{"R2", "R4", "R3", "R5", "R5", "R2", "R4"};
   localparam logic [1:0] T_OP [NV] = '{2'b01, 2'b10, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10};
   localparam logic [127:0] T_A [NV] = '{
      128'h00000001_00000002_00000004_00000008,
      128'h80000000_00000000_00000000_00000000,
      128'h00000000_00000000_00000000_00000000,
      128'h11111111_22222222_33333333_44444444,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'h00000000_00000000_00000000_40000000};
   localparam logic [127:0] T_B [NV] = '{
      128'h00000010_00000020_FFFFFFFF_FFFFFFFF,
      128'hDEADBEEF_00000000_00000000_00000000,
      128'hCAFEF00D_00000001_80000001_F0F0F0F0,
      128'h55555555_66666666_77777777_88888888,
      128'h12345678_12345678_12345678_12345678,
      128'h12345678_9ABCDEF0_AAAAAAAA_55555555,
      128'hFFFFFFFF_00000000_00000000_00000000};
   localparam logic [127:0] T_EXP [NV] = '{
      128'h00000005_0000000A_00000014_00000028,
      128'h00000001_00000000_00000000_00000002,
      128'h00000002_00000003_E1E1E1E1_00000004,
      128'h0,
      128'h0,
      128'h00000000_00000000_EDCBA987_6543210F,
      128'h00000000_00000000_00000000_80000000};
   localparam logic T_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_a = a; op_b = b; res_ready = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   function automatic logic [31:0] rol1(input logic [31:0] x);
      return {x[30:0], x[31]};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0]  w [80];
      logic [127:0] part;
      logic [127:0] e1;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", {127'b0, res_valid}, 128'h0);
      chk("R1 data in reset", res_data, 128'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", {127'b0, op_ready}, 128'h1);
      chk("R1 valid after reset", {127'b0, res_valid}, 128'h0);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         run_op(T_OP[i], T_A[i], T_B[i]);
         chk({T_TAG[i], " data"}, res_data, T_EXP[i]);
         chk({T_TAG[i], " err"}, {127'b0, res_err}, {127'b0, T_ERR[i]});
      end

      // R6 latency, R7 hold, R8 same-edge hand-off
      @(negedge clk);
      res_ready = 1'b0;
      op_valid = 1'b1; op_code = T_OP[0]; op_a = T_A[0]; op_b = T_B[0];
      chk("R6 not yet valid", {127'b0, res_valid}, 128'h0);
      @(negedge clk);
      chk("R6 valid one edge later", {127'b0, res_valid}, 128'h1);
      chk("R6 result", res_data, T_EXP[0]);
      e1 = res_data;
      op_code = T_OP[1]; op_a = T_A[1]; op_b = T_B[1];
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R7 data held", res_data, e1);
         chk("R7 ready low", {127'b0, op_ready}, 128'h0);
      end
      res_ready = 1'b1;
      #0.1;
      chk("R8 ready follows consume", {127'b0, op_ready}, 128'h1);
      @(negedge clk);
      chk("R8 valid kept", {127'b0, res_valid}, 128'h1);
      chk("R8 replaced result", res_data, T_EXP[1]);
      op_valid = 1'b0;
      @(negedge clk);
      chk("R8 drained", {127'b0, res_valid}, 128'h0);

      // R9: full 80-word expansion through chained stages
      for (int i = 0; i < 16; i++) w[i] = (32'h9E3779B9 * (i + 1)) ^ (32'(i) << 24);
      for (int t = 16; t < 80; t++) w[t] = rol1(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16]);
      for (int t = 16; t < 80; t += 4) begin
         run_op(2'b01, {w[t-16], w[t-15], w[t-14], w[t-13]},
                       {w[t-12], w[t-11], 32'h0, 32'h0});
         part = res_data ^ {w[t-8], w[t-7], w[t-6], w[t-5]};
         run_op(2'b10, part, {w[t-4], w[t-3], w[t-2], w[t-1]});
         chk("R9 expanded group", res_data, {w[t], w[t+1], w[t+2], w[t+3]});
      end

      finish_run();
   end

endmodule